// File: doc/BRIEF.md
# Pop-Free Reconfiguration Sequencer

This block is the control state machine that wraps a soft-stepping digital volume stage. It keeps the audio output from changing abruptly when the filtering path is reconfigured and when the output path is powered up or down. When the requested processing selection (de-emphasis and effects choice, carried as one code) differs from the code in use, the block forces the volume target to mute. It waits for the volume stage to report that it has settled, hands the new code to the filtering path, and then releases the mute so that the volume climbs back to the programmed level.

Power requests are handled in the same way. On power-up the path is enabled while the volume still sits at mute, and the volume then ramps up. On power-down the volume first ramps down to mute. Only after that does the power enable drop and the completion flag rise. All sequencing advances on the sample strobe. When soft-stepping is turned off, every fade is taken as finished at the next strobe, and the volume stage's settle report is not used. The interface consists of plain control and status pins. No data stream passes through the block, so it has no handshake.

Top module: `rcfg_seq`

## Requirements
- R1: After reset, power_en=0, force_mute=1, pdown_done=0 and mode_active equals the parameter MODE_RST.
- R2: The enable, mute and done outputs change only on a clock edge at which sample_tick=1.
- R3: While the path is off, a strobe with power_req=1 sets power_en=1 and force_mute=0 on that edge. The volume stage, held at mute until then, ramps up from mute.
- R4: While the path is off (both before the first power-up and after a power-down), mode_active takes the value of mode_req on every clock edge, so it reflects mode_req one clock later.
- R5: While powered and steady, a strobe that sees mode_req different from mode_active sets force_mute=1. mode_active keeps its old value until the strobe on which the mute fade completes. On that edge mode_active takes mode_req and force_mute returns to 0.
- R6: The apply step lasts exactly one sample period. The next strobe goes on to the ramp-up with force_mute=0, even when mode_req changed again during the apply step.
- R7: A selection change seen during the ramp-up does not disturb it. On the strobe that completes the ramp, the block goes straight into a mute fade (force_mute=1).
- R8: A strobe with power_req=0 while powered sets force_mute=1 and keeps power_en=1. On the strobe that completes the fade, power_en falls to 0 and pdown_done rises to 1.
- R9: A power-down request takes priority over a pending selection change. mode_active is not updated during the fade-out and is updated only once the path is off.
- R10: A fade is complete on a strobe with vol_done=1 when soft_en=1. When soft_en=0, any strobe completes it whatever the value of vol_done.
- R11: pdown_done stays 1 until the strobe that starts a new power-up, and clears on that edge.
- R12: Raising power_req during the fade-out does not cut it short. The block still reaches the off state with pdown_done=1, and the power-up starts on a later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-clock strobe per audio sample |
| soft_en | input | 1 | 1 = fades wait for vol_done; 0 = fades end at the next strobe |
| power_req | input | 1 | Level: 1 requests the output path on |
| mode_req | input | MODE_W | Requested processing selection code |
| vol_done | input | 1 | Volume stage reports actual volume equals its target |
| force_mute | output | 1 | Forces the volume stage target to mute |
| mode_active | output | MODE_W | Selection code in use by the filtering path |
| power_en | output | 1 | Enable for the output path circuitry |
| pdown_done | output | 1 | Fade-out and power-down have completed |

## Verification
The state register drives power_en, force_mute and pdown_done directly. Each of these therefore changes on the same edge that samples the strobe, and the mode register updates on the edge that ends the mute fade. The only exception is the off state, where mode_active follows mode_req one edge after a change. The bench raises a strobe for one clock between falling edges and reads the outputs at the next falling edge, so each result is read exactly one edge after its cause. It also inserts strobe-free clocks to show that nothing moves without a strobe.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_RAMP_UP  = 3'd1,
    ST_ACTIVE   = 3'd2,
    ST_MUTE_CHG = 3'd3,
    ST_APPLY    = 3'd4,
    ST_MUTE_OFF = 3'd5,
    ST_DONE     = 3'd6
  } seq_st_e;
endpackage

// File: rtl/rcfg_fade_gate.sv
module rcfg_fade_gate (
  input  logic sample_tick,
  input  logic soft_en,
  input  logic vol_done,
  output logic fade_ok
);
  // with soft-stepping off the volume jumps at the next sample
  assign fade_ok = sample_tick & (vol_done | ~soft_en);
endmodule

// File: rtl/rcfg_mode_reg.sv
module rcfg_mode_reg #(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] MODE_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              load,
  output logic [MODE_W-1:0] mode_q,
  output logic              pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= MODE_RST;
    else if (load) mode_q <= mode_req;
  end

  assign pending = (mode_req != mode_q);
endmodule

// File: rtl/rcfg_fsm.sv
module rcfg_fsm
  import rcfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sample_tick,
  input  logic    power_req,
  input  logic    fade_ok,
  input  logic    pending,
  output seq_st_e st,
  output logic    load_mode
);
  seq_st_e st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_OFF, ST_DONE:
        if (sample_tick && power_req) st_nx = ST_RAMP_UP;
      ST_RAMP_UP:
        if (sample_tick && !power_req) st_nx = ST_MUTE_OFF;
        else if (fade_ok)              st_nx = pending ? ST_MUTE_CHG : ST_ACTIVE;
      ST_ACTIVE:
        if (sample_tick && !power_req)  st_nx = ST_MUTE_OFF;
        else if (sample_tick && pending) st_nx = ST_MUTE_CHG;
      ST_MUTE_CHG:
        if (sample_tick && !power_req) st_nx = ST_MUTE_OFF;
        else if (fade_ok)              st_nx = ST_APPLY;
      ST_APPLY:
        if (sample_tick && !power_req) st_nx = ST_MUTE_OFF;
        else if (sample_tick)          st_nx = ST_RAMP_UP;
      ST_MUTE_OFF:
        if (fade_ok) st_nx = ST_DONE;
      default: st_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= st_nx;
  end

  // off: follow the request; muted for a change: take it as the fade ends
  assign load_mode = (st == ST_OFF) || (st == ST_DONE) ||
                     ((st == ST_MUTE_CHG) && fade_ok && power_req);
endmodule

// File: rtl/rcfg_seq.sv
module rcfg_seq
  import rcfg_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] MODE_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              soft_en,
  input  logic              power_req,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              vol_done,
  output logic              force_mute,
  output logic [MODE_W-1:0] mode_active,
  output logic              power_en,
  output logic              pdown_done
);
  logic    fade_ok;
  logic    pending;
  logic    load_mode;
  seq_st_e st;

  rcfg_fade_gate u_gate (
    .sample_tick (sample_tick),
    .soft_en     (soft_en),
    .vol_done    (vol_done),
    .fade_ok     (fade_ok)
  );

  rcfg_mode_reg #(.MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_req),
    .load     (load_mode),
    .mode_q   (mode_active),
    .pending  (pending)
  );

  rcfg_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .power_req   (power_req),
    .fade_ok     (fade_ok),
    .pending     (pending),
    .st          (st),
    .load_mode   (load_mode)
  );

  assign power_en   = (st != ST_OFF) && (st != ST_DONE);
  assign force_mute = (st == ST_OFF) || (st == ST_DONE) ||
                      (st == ST_MUTE_CHG) || (st == ST_MUTE_OFF);
  assign pdown_done = (st == ST_DONE);
endmodule

// File: rtl/rcfg_seq_chk.sv
module rcfg_seq_chk
  import rcfg_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_tick,
  input logic              force_mute,
  input logic [MODE_W-1:0] mode_active,
  input logic              power_en,
  input logic              pdown_done,
  input seq_st_e           st
);
  // R5 R9: while powered, the code changes only on entering the apply step
  p_mode_at_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (power_en && $past(power_en) && (mode_active != $past(mode_active)))
      |-> (st == ST_APPLY));

  // R2: the sequencer moves only on a strobe
  p_move_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> $past(sample_tick));

  // R3: power is enabled only from a muted, off path
  p_rise_from_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_en) |-> ($past(force_mute) && st == ST_RAMP_UP));

  // R8: power drops only after the fade-out, with the mute forced
  p_fall_after_fade_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_en) |-> ($past(st) == ST_MUTE_OFF && $past(force_mute) && pdown_done));

  // R6: apply lasts a single sample period
  p_apply_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_APPLY && sample_tick) |=> (st != ST_APPLY));

  // R11: the done flag never coexists with power
  p_done_unpowered_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_done |-> !power_en);
endmodule

bind rcfg_seq rcfg_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_tick (sample_tick),
  .force_mute  (force_mute),
  .mode_active (mode_active),
  .power_en    (power_en),
  .pdown_done  (pdown_done),
  .st          (st)
);

// File: tb/sim_rcfg_seq.sv
module sim_rcfg_seq;
  localparam int MW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic soft_en = 1'b0;
  logic power_req = 1'b0;
  logic [MW-1:0] mode_req = '0;
  logic vol_done = 1'b0;
  logic force_mute, power_en, pdown_done;
  logic [MW-1:0] mode_active;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rcfg_seq #(.MODE_W(MW), .MODE_RST('0)) u0 (
    .clk, .rst_n, .sample_tick, .soft_en, .power_req, .mode_req, .vol_done,
    .force_mute, .mode_active, .power_en, .pdown_done
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp=<%0d cycles", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // {power_en, force_mute, pdown_done}
  function automatic int outs();
    return {29'd0, power_en, force_mute, pdown_done};
  endfunction

  task automatic tick(input logic vd);
    @(negedge clk);
    vol_done = vd;
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      for (int m = 1; m < 8; m++) begin
        logic [MW-1:0] m2;
        m2 = MW'(m) ^ 3'b111;
        // reset
        @(negedge clk);
        rst_n = 1'b0; soft_en = s[0]; power_req = 1'b0; mode_req = '0; vol_done = 1'b0;
        idle(); idle();
        rst_n = 1'b1;
        idle();
        chk("R1 outs", outs(), 3'b010);
        chk("R1 mode", int'(mode_active), 0);

        // R4: code follows the request while off
        mode_req = MW'(m);
        idle();
        chk("R4 follow", int'(mode_active), m);
        mode_req = '0;
        idle();
        chk("R4 follow back", int'(mode_active), 0);

        // R2: no movement without a strobe
        power_req = 1'b1;
        idle(); idle();
        chk("R2 no strobe", outs(), 3'b010);

        // R3: power-up
        tick(1'b0);
        chk("R3 power up", outs(), 3'b100);

        // R7/R10: change during ramp-up
        mode_req = MW'(m);
        tick(1'b0);
        chk("R10 R7 ramp end", int'(force_mute), (s == 0) ? 1 : 0);
        if (s == 1) begin
          tick(1'b1);
          chk("R7 serviced", outs(), 3'b110);
          chk("R5 mode held", int'(mode_active), 0);
          tick(1'b0);
          chk("R10 wait done", outs(), 3'b110);
          chk("R5 mode held2", int'(mode_active), 0);
          tick(1'b1);
        end else begin
          tick(1'b0);
        end
        chk("R5 applied", int'(mode_active), m);
        chk("R5 unmute", outs(), 3'b100);

        // R6: new change during apply does not prolong it
        mode_req = m2;
        tick(1'b1);
        chk("R6 to ramp", outs(), 3'b100);
        chk("R6 mode", int'(mode_active), m);
        tick(1'b1);
        chk("R7 pending after ramp", outs(), 3'b110);
        chk("R5 mode held3", int'(mode_active), m);
        tick(1'b1);
        chk("R5 apply2", int'(mode_active), int'(m2));
        tick(1'b1);
        tick(1'b1);
        chk("R5 active", outs(), 3'b100);

        // R9/R8: power-down with pending change
        power_req = 1'b0;
        mode_req = MW'(m);
        tick(1'b1);
        chk("R8 fade out", outs(), 3'b110);
        chk("R9 mode kept", int'(mode_active), int'(m2));
        tick(1'b0);
        if (s == 1) begin
          chk("R10 fade held", outs(), 3'b110);
          power_req = 1'b1;
          tick(1'b0);
          chk("R12 no abort", outs(), 3'b110);
          chk("R9 mode kept2", int'(mode_active), int'(m2));
          tick(1'b1);
        end
        chk("R8 off", outs(), 3'b011);
        idle();
        chk("R9 mode after off", int'(mode_active), m);
        power_req = 1'b1;
        idle();
        chk("R11 done held", outs(), 3'b011);
        tick(1'b0);
        chk("R11 power up clears", outs(), 3'b100);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule